// File: doc/BRIEF.md
# Stop-Sequenced Clock Gating Unit

This block gates a bank of single-ended bus clocks and one differential clock pair in response to a stop request. The stop request comes from an active-low pin or from a register run bit. The request is sampled only on rising edges of a free-running reference bus clock. All clock inputs are handled as oversampled levels in a fast system clock domain. Each gated output is a registered copy of its source, and the copy is held at a fixed level when stopped.

Stopping runs in a fixed order. First every stoppable bus clock finishes its current high phase and is held low. Only when all of them are held does the differential pair finish a high phase of its true line and park. Parked means true high and complement low, or both undriven when the stop-tristate bit is set. A state code reports whether the pair is running, parked, undriven or disabled. Outputs marked free-running ignore both stop sources. A per-output enable forces a clock low whatever the stop state.

Top module: `clkstop_gate_top`

## Requirements
- R1: The combined stop request (pin low or run bit low) is captured only on a rising edge of `ref_bus_clk_i`. A pin pulse that begins and ends while the reference is low, with no reference rising edge in between, has no effect on any output.
- R2: When a stop is captured, each stoppable bus output completes its current high phase and then stays low for as long as the stop remains captured.
- R3: The stoppable pair parks only after every stoppable bus output is held low. It parks at the end of a high phase of its source. Parked shows `diff_true_o`=1, `diff_comp_o`=0 and `diff_state_o`=1.
- R4: With `cfg_pair_tri_i`=1, a stopped pair shows `diff_state_o`=2 (undriven), with both `diff_true_o` and `diff_comp_o` at 0.
- R5: `cfg_free_run_i` bit i (for i below NUM_BUS) makes bus output i free-running. Bit NUM_BUS makes the pair free-running. A free-running output ignores both the pin and the run bit, keeps following its source, and the pair stays at state 0.
- R6: After the stop is withdrawn, stopped outputs restart with full-width high phases only. The pair returns to `diff_state_o`=0 within 24 system cycles of the pin release.
- R7: `cfg_run_en_i`=0 stops every stoppable output exactly as a low pin does.
- R8: `cfg_bus_oe_i` bit i = 0 holds bus output i low. `cfg_pair_oe_i`=0 drives both pair lines low and shows `diff_state_o`=3.
- R9: During reset all bus outputs and both pair lines are 0, and `diff_state_o` is 0.
- R10: While running, each bus output equals its source as sampled two system cycles earlier. `diff_true_o` follows the pair source with the same delay, and `diff_comp_o` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples every clock input |
| rst | input | 1 | Synchronous active-high reset |
| ref_bus_clk_i | input | 1 | Free-running reference bus clock level |
| bus_clk_i | input | NUM_BUS | Raw bus clock levels |
| pair_clk_i | input | 1 | Raw differential clock level |
| stop_n_i | input | 1 | Active-low stop request pin |
| cfg_run_en_i | input | 1 | Register run bit; 0 requests a stop |
| cfg_free_run_i | input | NUM_BUS+1 | Free-running flags, bus bits low, pair bit on top |
| cfg_bus_oe_i | input | NUM_BUS | Per-bus-output enable |
| cfg_pair_oe_i | input | 1 | Pair enable |
| cfg_pair_tri_i | input | 1 | 1: stopped pair undriven; 0: parked high |
| bus_clk_o | output | NUM_BUS | Gated bus clocks |
| diff_true_o | output | 1 | Gated true line of the pair |
| diff_comp_o | output | 1 | Gated complement line of the pair |
| diff_state_o | output | 2 | 0 run, 1 parked, 2 undriven, 3 disabled |

## Verification
The assertions check several properties on every cycle. A captured stop changes only right after a reference rising edge. Gated bus edges only follow source edges of the proper polarity, so no pulse is ever shortened. The pair parks only at the end of a source high phase and never while a stoppable bus output is still high. Free-running outputs keep passing their sources through. Other behaviour shows only in the bench's scenarios: a short pin pulse being ignored, the parked and undriven levels over a sweep of free-run masks and stop sources, the resume latency and the output-enable overrides.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    DS_RUN  = 2'd0,
    DS_PARK = 2'd1,
    DS_TRI  = 2'd2,
    DS_OFF  = 2'd3
  } pair_state_e;
endpackage

// File: rtl/clkstop_sampler.sv
module clkstop_sampler (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  input  logic stop_n_i,
  input  logic run_en_i,
  output logic stop_o
);
  logic ref_q, ref_d, req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      ref_d  <= 1'b0;
      req_q  <= 1'b0;
      stop_o <= 1'b0;
    end else begin
      ref_q <= ref_clk_i;
      ref_d <= ref_q;
      req_q <= ~stop_n_i | ~run_en_i;
      if (ref_q && !ref_d) stop_o <= req_q;
    end
  end

  AST_STOP_ON_REF_RISE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && !$stable(stop_o))
      |-> ($past(ref_clk_i, 2) && !$past(ref_clk_i, 3))); // R1
endmodule

// File: rtl/clkstop_bus_cell.sv
module clkstop_bus_cell (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic stop_i,
  input  logic oe_i,
  output logic clk_o,
  output logic run_o
);
  logic src_q;

  // run_o may only change while the sampled source sits low
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= 1'b0;
      run_o <= 1'b1;
      clk_o <= 1'b0;
    end else begin
      src_q <= src_i;
      if (!src_q) run_o <= !stop_i && oe_i;
      clk_o <= src_q & run_o;
    end
  end

  AST_BUS_RISE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> ($past(src_q) && !$past(src_q, 2))); // R6
  AST_BUS_FALL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_o) |-> !$past(src_q)); // R2
endmodule

// File: rtl/clkstop_pair_gate.sv
module clkstop_pair_gate
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        src_i,
  input  logic        stop_i,
  input  logic        bus_quiet_i,
  input  logic        oe_i,
  input  logic        tri_i,
  output logic        true_o,
  output logic        comp_o,
  output pair_state_e state_o
);
  logic src_q, run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= 1'b0;
      run_q   <= 1'b1;
      true_o  <= 1'b0;
      comp_o  <= 1'b0;
      state_o <= DS_RUN;
    end else begin
      src_q <= src_i;
      if (src_q) begin
        if (stop_i && bus_quiet_i) run_q <= 1'b0;
        else if (!stop_i)          run_q <= 1'b1;
      end
      if (!oe_i) begin
        true_o <= 1'b0; comp_o <= 1'b0; state_o <= DS_OFF;
      end else if (run_q) begin
        true_o <= src_q; comp_o <= !src_q; state_o <= DS_RUN;
      end else if (tri_i) begin
        true_o <= 1'b0; comp_o <= 1'b0; state_o <= DS_TRI;
      end else begin
        true_o <= 1'b1; comp_o <= 1'b0; state_o <= DS_PARK;
      end
    end
  end

  AST_PAIR_PARK_AT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_o == DS_PARK && $past(state_o) == DS_RUN) |-> $past(src_q, 2)); // R3
endmodule

// File: rtl/clkstop_gate_top.sv
module clkstop_gate_top
  import clkstop_pkg::*;
#(
  parameter int NUM_BUS = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_bus_clk_i,
  input  logic [NUM_BUS-1:0] bus_clk_i,
  input  logic               pair_clk_i,
  input  logic               stop_n_i,
  input  logic               cfg_run_en_i,
  input  logic [NUM_BUS:0]   cfg_free_run_i,
  input  logic [NUM_BUS-1:0] cfg_bus_oe_i,
  input  logic               cfg_pair_oe_i,
  input  logic               cfg_pair_tri_i,
  output logic [NUM_BUS-1:0] bus_clk_o,
  output logic               diff_true_o,
  output logic               diff_comp_o,
  output logic [1:0]         diff_state_o
);
  localparam int PAIR_IDX = NUM_BUS;

  logic               stop_s;
  logic [NUM_BUS-1:0] bus_stop, bus_run, bus_quiet;
  logic               pair_stop;
  pair_state_e        pair_state;

  clkstop_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .ref_clk_i (ref_bus_clk_i),
    .stop_n_i  (stop_n_i),
    .run_en_i  (cfg_run_en_i),
    .stop_o    (stop_s)
  );

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    assign bus_stop[g]  = stop_s & ~cfg_free_run_i[g];
    assign bus_quiet[g] = ~bus_stop[g] | ~bus_run[g];
    clkstop_bus_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .src_i  (bus_clk_i[g]),
      .stop_i (bus_stop[g]),
      .oe_i   (cfg_bus_oe_i[g]),
      .clk_o  (bus_clk_o[g]),
      .run_o  (bus_run[g])
    );
  end

  assign pair_stop = stop_s & ~cfg_free_run_i[PAIR_IDX];

  clkstop_pair_gate u_pair (
    .clk         (clk),
    .rst         (rst),
    .src_i       (pair_clk_i),
    .stop_i      (pair_stop),
    .bus_quiet_i (&bus_quiet),
    .oe_i        (cfg_pair_oe_i),
    .tri_i       (cfg_pair_tri_i),
    .true_o      (diff_true_o),
    .comp_o      (diff_comp_o),
    .state_o     (pair_state)
  );

  assign diff_state_o = pair_state;

  logic [NUM_BUS-1:0] free_live;
  assign free_live = cfg_free_run_i[NUM_BUS-1:0] & cfg_bus_oe_i;

  AST_PARK_AFTER_BUS: assert property (@(posedge clk) disable iff (rst)
    (stop_s && (pair_state == DS_PARK || pair_state == DS_TRI))
      |-> ((bus_clk_o & ~cfg_free_run_i[NUM_BUS-1:0]) == '0)); // R3
  AST_FREE_BUS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && free_live == $past(free_live)
      && free_live == $past(free_live, 2))
      |-> ((bus_clk_o & free_live) == ($past(bus_clk_i, 2) & free_live))); // R5
  AST_FREE_PAIR_RUNS: assert property (@(posedge clk) disable iff (rst)
    (cfg_free_run_i[PAIR_IDX] && cfg_pair_oe_i && $past(cfg_pair_oe_i)
      && $past(cfg_free_run_i[PAIR_IDX])) |-> (pair_state == DS_RUN)); // R5
endmodule

// File: tb/clkstop_gate_top_test.sv
module clkstop_gate_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 3;
  localparam int BUSP = 8;
  localparam int HALF = 4;
  localparam int PAIRP = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_clk = 1'b0, pair_i = 1'b0, stop_n = 1'b1, run_en = 1'b1;
  logic [NB-1:0] bus_i = '0, oe = '1;
  logic [NB:0] free = '0;
  logic pair_oe = 1'b1, pair_tri = 1'b0;
  logic [NB-1:0] bus_o;
  logic pair_t, pair_c;
  logic [1:0] pair_state;

  clkstop_gate_top #(.NUM_BUS(NB)) uut (
    .clk(clk), .rst(rst), .ref_bus_clk_i(ref_clk), .bus_clk_i(bus_i),
    .pair_clk_i(pair_i), .stop_n_i(stop_n), .cfg_run_en_i(run_en),
    .cfg_free_run_i(free), .cfg_bus_oe_i(oe), .cfg_pair_oe_i(pair_oe),
    .cfg_pair_tri_i(pair_tri), .bus_clk_o(bus_o), .diff_true_o(pair_t),
    .diff_comp_o(pair_c), .diff_state_o(pair_state));

  int cyc = 0, checks = 0, errors = 0;
  int glitch_cnt = 0, order_cnt = 0, lat_cnt = 0;
  int hlen[NB];
  int bus_hi[NB];
  int t_hi = 0, c_hi = 0, st_mis = 0;
  logic [NB-1:0] p1 = '0, lat_mask = '0;
  logic d1 = 1'b0;
  bit lat_pair = 0, stop_held = 0, mon_on = 0, done = 0;

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // stimulus generator and cycle monitors
  initial forever begin
    @(negedge clk);
    if (mon_on) begin
      for (int i = 0; i < NB; i++) begin
        if (bus_o[i]) begin
          if (hlen[i] >= 0) hlen[i]++;
        end else begin
          if (hlen[i] > 0 && hlen[i] != HALF) glitch_cnt++;
          hlen[i] = 0;
        end
      end
      if (stop_held && (pair_state == 2'd1 || pair_state == 2'd2)
          && ((bus_o & ~free[NB-1:0]) != '0)) order_cnt++;
      if ((bus_o & lat_mask) != (p1 & lat_mask)) lat_cnt++;
      if (lat_pair && (pair_t !== d1 || pair_c !== ~d1)) lat_cnt++;
    end
    p1 = bus_i;
    d1 = pair_i;
    cyc++;
    ref_clk = (cyc % BUSP) < HALF;
    for (int i = 0; i < NB; i++) bus_i[i] = ((cyc + 2*i) % BUSP) < HALF;
    pair_i = (cyc % PAIRP) < (PAIRP/2);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(logic [NB:0] fr, logic [NB-1:0] oe_v, logic poe, logic ptri);
    mon_on = 0;
    rst = 1; free = fr; oe = oe_v; pair_oe = poe; pair_tri = ptri;
    stop_n = 1; run_en = 1; stop_held = 0; lat_mask = '0; lat_pair = 0;
    tick(4);
    rst = 0;
    tick(12);
    glitch_cnt = 0; order_cnt = 0; lat_cnt = 0;
    for (int i = 0; i < NB; i++) hlen[i] = -1;
    mon_on = 1;
  endtask

  task automatic observe(int n, logic [1:0] exp_state);
    for (int i = 0; i < NB; i++) bus_hi[i] = 0;
    t_hi = 0; c_hi = 0; st_mis = 0;
    repeat (n) begin
      tick(1);
      for (int i = 0; i < NB; i++) if (bus_o[i]) bus_hi[i]++;
      if (pair_t) t_hi++;
      if (pair_c) c_hi++;
      if (pair_state != exp_state) st_mis++;
    end
  endtask

  task automatic run_stop(logic [NB:0] fr, bit use_reg, bit ptri);
    int w;
    logic [1:0] exp_st;
    restart(fr, '1, 1'b1, ptri);
    lat_mask = '1; lat_pair = 1; lat_cnt = 0;
    observe(32, 2'd0);
    check(lat_cnt == 0, "R10 pass-through", lat_cnt, 0);
    check(st_mis == 0, "R10 run state", st_mis, 0);
    lat_mask = fr[NB-1:0]; lat_pair = fr[NB]; lat_cnt = 0; order_cnt = 0;
    stop_held = 1;
    if (use_reg) run_en = 0; else stop_n = 0;
    tick(40);
    exp_st = fr[NB] ? 2'd0 : (ptri ? 2'd2 : 2'd1);
    observe(24, exp_st);
    for (int i = 0; i < NB; i++)
      if (!fr[i]) check(bus_hi[i] == 0, use_reg ? "R7 bus held" : "R2 bus held", bus_hi[i], 0);
    check(lat_cnt == 0, "R5 free outputs follow", lat_cnt, 0);
    check(st_mis == 0, fr[NB] ? "R5 pair free" : (ptri ? "R4 state" : "R3 state"),
          st_mis, 0);
    if (!fr[NB]) begin
      if (ptri) check(t_hi == 0 && c_hi == 0, "R4 levels", t_hi + c_hi, 0);
      else      check(t_hi == 24 && c_hi == 0, "R3 levels", t_hi - c_hi, 24);
    end
    check(order_cnt == 0, "R3 order", order_cnt, 0);
    stop_held = 0; stop_n = 1; run_en = 1; lat_pair = 0;
    w = 0;
    while (pair_state != 2'd0 && w < 100) begin tick(1); w++; end
    check(w <= 3*BUSP, "R6 resume latency", w, 3*BUSP);
    tick(30);
    lat_mask = '1; lat_pair = 1; lat_cnt = 0;
    observe(24, 2'd0);
    check(lat_cnt == 0, "R6 resumed", lat_cnt, 0);
    check(glitch_cnt == 0, "R6 no short pulse", glitch_cnt, 0);
  endtask

  initial begin
    // R9: reset state
    tick(3);
    check(bus_o == '0, "R9 bus", int'(bus_o), 0);
    check(pair_t == 1'b0 && pair_c == 1'b0, "R9 pair lines", int'({pair_t, pair_c}), 0);
    check(pair_state == 2'd0, "R9 state", int'(pair_state), 0);

    // R1: short pin pulse between reference rises is ignored
    restart('0, '1, 1'b1, 1'b0);
    lat_mask = '1; lat_pair = 1; lat_cnt = 0;
    while (cyc % BUSP != HALF) tick(1);
    stop_n = 0;
    tick(2);
    stop_n = 1;
    observe(40, 2'd0);
    check(st_mis == 0, "R1 pulse ignored state", st_mis, 0);
    check(lat_cnt == 0, "R1 pulse ignored clocks", lat_cnt, 0);
    // R1: a pin low across a reference rise is taken
    lat_mask = '0; lat_pair = 0;
    while (cyc % BUSP != HALF) tick(1);
    stop_n = 0;
    observe(30, 2'd1);
    check(st_mis < 30, "R1 held request taken", st_mis, 29);
    stop_n = 1;
    tick(40);

    for (int fr = 0; fr < (1 << (NB+1)); fr++)
      for (int src = 0; src < 2; src++)
        for (int tr = 0; tr < 2; tr++)
          run_stop(fr[NB:0], src[0], tr[0]);

    // R8: output enables
    for (int ov = 0; ov < (1 << NB); ov++)
      for (int po = 0; po < 2; po++) begin
        restart('0, ov[NB-1:0], po[0], 1'b0);
        lat_mask = ov[NB-1:0]; lat_pair = po[0]; lat_cnt = 0;
        observe(24, po[0] ? 2'd0 : 2'd3);
        for (int i = 0; i < NB; i++)
          if (!ov[i]) check(bus_hi[i] == 0, "R8 bus disabled", bus_hi[i], 0);
        check(lat_cnt == 0, "R8 enabled outputs", lat_cnt, 0);
        check(st_mis == 0, "R8 pair state", st_mis, 0);
        if (!po[0]) check(t_hi == 0 && c_hi == 0, "R8 pair low", t_hi + c_hi, 0);
      end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule